// File: doc/BRIEF.md
# Memory Bit Manipulation Unit

This unit carries out the single-bit and test-and-modify instructions of an 8-bit accumulator processor. It handles clearing or setting one bit of a zero-page byte, branching on the state of one bit of a zero-page byte, the test-and-set and test-and-reset instructions, and the bit-test instruction in its immediate, zero-page and absolute forms. Instruction fetch and the general ALU stay outside the block.

The surrounding core pulses `start` with the opcode, both operand bytes, the accumulator and the address of the next instruction. The unit then works through its own memory accesses, which are one read and possibly one write. Memory answers a read one cycle after `mem_rd`. When the last access is over, the unit pulses `done`. At that point the flag updates, the branch decision, the branch target and the cycle count are valid, and they stay held until the next accepted start.

The controller is a five-state machine:
- IDLE waits for `start`. From IDLE it moves to READ for any memory-form opcode, to EVAL for immediate bit-test, and to FINISH for an opcode it does not support.
- READ drives `mem_rd` and always moves to EVAL.
- EVAL captures the read data and computes the results. It moves to WRITE for the three modifying kinds and to FINISH for all others.
- WRITE drives `mem_wr` and moves to FINISH.
- FINISH drives `done` and returns to IDLE.

Top module: `membit_unit`

## Requirements
- R1: An opcode whose low nibble is 0x7 writes the zero-page byte at `{0x00, oper_lo}` back with bit opcode[6:4] cleared when opcode[7]=0, or set when opcode[7]=1. All other bits are unchanged, and `cycles` is 5.
- R2: An opcode whose low nibble is 0xF reads the zero-page byte at `oper_lo`. `br_taken` is 1 exactly when bit opcode[6:4] of that byte equals opcode[7]. `br_offset` is `oper_hi`. `cycles` is 3 when taken and 2 otherwise, and nothing is written.
- R3: `br_target` equals `next_pc` plus `oper_hi` sign-extended, modulo 65536.
- R4: Opcodes 0x04/0x0C (test-and-set) and 0x14/0x1C (test-and-reset) set `flag_z` to 1 exactly when (memory AND accumulator) is zero, with `flag_z_we`=1. Test-and-set writes memory OR accumulator. Test-and-reset writes memory AND NOT accumulator.
- R5: Opcodes 0x04 and 0x14 address `{0x00, oper_lo}` and report 3 cycles. Opcodes 0x0C and 0x1C address `{oper_hi, oper_lo}` and report 4 cycles.
- R6: Opcode 0x89 sets Z from (`oper_lo` AND accumulator) and leaves N and V alone (`flag_nv_we`=0). It makes no memory access, reports 2 cycles, and raises `done` two cycles after start.
- R7: Opcode 0x24 (zero-page, 3 cycles) and opcode 0x2C (absolute, 4 cycles) set Z from (memory AND accumulator), N from memory bit 7 and V from memory bit 6, with `flag_nv_we`=1. They write nothing.
- R8: After a start is accepted, `mem_rd` is high in the first cycle. Read data is taken in the second cycle. `mem_wr`, if the instruction writes, is high in the third cycle. `done` is high for one cycle right after the last access. `busy` is high from the cycle after start until `done`, and the read and write strobes are never high together.
- R9: `start` while `busy` is ignored. No second access and no second `done` follow it.
- R10: Any other opcode makes no memory access and no flag update. It gives `br_taken`=0 and `cycles`=0, and `done` rises in the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| opcode | input | 8 | Instruction opcode |
| oper_lo | input | 8 | First operand byte (address low / immediate) |
| oper_hi | input | 8 | Second operand byte (address high / branch offset) |
| acc | input | 8 | Accumulator value |
| next_pc | input | ADDR_W | Address of the following instruction |
| mem_addr | output | ADDR_W | Memory address for this instruction |
| mem_rd | output | 1 | Read strobe, data expected the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| flag_z_we | output | 1 | Z update enable |
| flag_z | output | 1 | New Z value |
| flag_nv_we | output | 1 | N and V update enable |
| flag_n | output | 1 | New N value |
| flag_v | output | 1 | New V value |
| br_taken | output | 1 | Branch on bit is taken |
| br_offset | output | 8 | Signed branch offset |
| br_target | output | ADDR_W | Branch destination |
| cycles | output | 3 | Cycle count of the instruction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions rely on two things: memory returns read data exactly one cycle after `mem_rd`, and the caller never expects a start to be taken while `busy` is high. The bench memory model registers its read on the clock edge that ends the read cycle. Inputs change only on the falling edge, and each new instruction is issued only after `done`, except in the one scenario that deliberately pulses `start` mid-instruction to exercise R9.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int CYC_W  = 3;

    typedef enum logic [2:0] {
        K_NONE,
        K_BITMOD,
        K_BRBIT,
        K_TSET,
        K_TCLR,
        K_TEST_IMM,
        K_TEST_MEM
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             absolute;
        logic [IDX_W-1:0] idx;
        logic             pol;
        logic [CYC_W-1:0] base_cyc;
    } dec_t;
endpackage

// File: rtl/membit_decode.sv
module membit_decode
    import bitop_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output dec_t              dec
);
    always_comb begin
        dec          = '0;
        dec.kind     = K_NONE;
        dec.idx      = opcode[6:4];
        dec.pol      = opcode[7];
        if (opcode[3:0] == 4'h7) begin
            dec.kind     = K_BITMOD;
            dec.base_cyc = CYC_W'(5);
        end else if (opcode[3:0] == 4'hF) begin
            dec.kind     = K_BRBIT;
            dec.base_cyc = CYC_W'(2);
        end else begin
            unique case (opcode)
                8'h04: begin dec.kind = K_TSET; dec.base_cyc = CYC_W'(3); end
                8'h0C: begin dec.kind = K_TSET; dec.absolute = 1'b1; dec.base_cyc = CYC_W'(4); end
                8'h14: begin dec.kind = K_TCLR; dec.base_cyc = CYC_W'(3); end
                8'h1C: begin dec.kind = K_TCLR; dec.absolute = 1'b1; dec.base_cyc = CYC_W'(4); end
                8'h89: begin dec.kind = K_TEST_IMM; dec.base_cyc = CYC_W'(2); end
                8'h24: begin dec.kind = K_TEST_MEM; dec.base_cyc = CYC_W'(3); end
                8'h2C: begin dec.kind = K_TEST_MEM; dec.absolute = 1'b1; dec.base_cyc = CYC_W'(4); end
                default: dec.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/membit_alu.sv
module membit_alu
    import bitop_pkg::*;
(
    input  kind_e             kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic              pol,
    input  logic [BYTE_W-1:0] rd_val,
    input  logic [BYTE_W-1:0] imm,
    input  logic [BYTE_W-1:0] acc,
    output logic [BYTE_W-1:0] wr_val,
    output logic              z,
    output logic              n,
    output logic              v,
    output logic              hit
);
    logic [BYTE_W-1:0] val;
    logic [BYTE_W-1:0] mask;

    always_comb begin
        val  = (kind == K_TEST_IMM) ? imm : rd_val;
        mask = BYTE_W'(1) << idx;
        z    = ((val & acc) == '0);
        n    = val[BYTE_W-1];
        v    = val[BYTE_W-2];
        hit  = (val[idx] == pol);
        unique case (kind)
            K_TSET:   wr_val = val | acc;
            K_TCLR:   wr_val = val & ~acc;
            K_BITMOD: wr_val = pol ? (val | mask) : (val & ~mask);
            default:  wr_val = val;
        endcase
    end
endmodule

// File: rtl/membit_unit.sv
module membit_unit
    import bitop_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [BYTE_W-1:0]     opcode,
    input  logic [BYTE_W-1:0]     oper_lo,
    input  logic [BYTE_W-1:0]     oper_hi,
    input  logic [BYTE_W-1:0]     acc,
    input  logic [ADDR_W-1:0]     next_pc,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [BYTE_W-1:0]     mem_wdata,
    input  logic [BYTE_W-1:0]     mem_rdata,
    output logic                  flag_z_we,
    output logic                  flag_z,
    output logic                  flag_nv_we,
    output logic                  flag_n,
    output logic                  flag_v,
    output logic                  br_taken,
    output logic [BYTE_W-1:0]     br_offset,
    output logic [ADDR_W-1:0]     br_target,
    output logic [CYC_W-1:0]      cycles,
    output logic                  busy,
    output logic                  done
);
    localparam int EXT_W = ADDR_W - BYTE_W;

    typedef enum logic [2:0] {S_IDLE, S_READ, S_EVAL, S_WRITE, S_FINISH} state_e;

    state_e state, nxt;

    dec_t              dec_in, dec_q;
    logic [BYTE_W-1:0] lo_q, hi_q, acc_q, wdata_q;
    logic [ADDR_W-1:0] npc_q;
    logic              zwe_q, z_q, nvwe_q, n_q, v_q, taken_q;
    logic [CYC_W-1:0]  cyc_q;

    logic [BYTE_W-1:0] alu_wr;
    logic              alu_z, alu_n, alu_v, alu_hit, taken_nxt;
    logic              accept;

    membit_decode u_dec (
        .opcode (opcode),
        .dec    (dec_in)
    );

    membit_alu u_alu (
        .kind   (dec_q.kind),
        .idx    (dec_q.idx),
        .pol    (dec_q.pol),
        .rd_val (mem_rdata),
        .imm    (lo_q),
        .acc    (acc_q),
        .wr_val (alu_wr),
        .z      (alu_z),
        .n      (alu_n),
        .v      (alu_v),
        .hit    (alu_hit)
    );

    assign accept    = (state == S_IDLE) && start;
    assign taken_nxt = (dec_q.kind == K_BRBIT) && alu_hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (dec_in.kind == K_NONE)          nxt = S_FINISH;
                    else if (dec_in.kind == K_TEST_IMM) nxt = S_EVAL;
                    else                                nxt = S_READ;
                end
            end
            S_READ:  nxt = S_EVAL;
            S_EVAL: begin
                if (dec_q.kind == K_BITMOD || dec_q.kind == K_TSET || dec_q.kind == K_TCLR)
                    nxt = S_WRITE;
                else
                    nxt = S_FINISH;
            end
            S_WRITE:  nxt = S_FINISH;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // operand capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            acc_q   <= '0;
            npc_q   <= '0;
            wdata_q <= '0;
            zwe_q   <= 1'b0;
            z_q     <= 1'b0;
            nvwe_q  <= 1'b0;
            n_q     <= 1'b0;
            v_q     <= 1'b0;
            taken_q <= 1'b0;
            cyc_q   <= '0;
        end else if (accept) begin
            dec_q   <= dec_in;
            lo_q    <= oper_lo;
            hi_q    <= oper_hi;
            acc_q   <= acc;
            npc_q   <= next_pc;
            zwe_q   <= 1'b0;
            nvwe_q  <= 1'b0;
            z_q     <= 1'b0;
            n_q     <= 1'b0;
            v_q     <= 1'b0;
            taken_q <= 1'b0;
            cyc_q   <= dec_in.base_cyc;
        end else if (state == S_EVAL) begin
            wdata_q <= alu_wr;
            zwe_q   <= (dec_q.kind == K_TSET) || (dec_q.kind == K_TCLR) ||
                       (dec_q.kind == K_TEST_IMM) || (dec_q.kind == K_TEST_MEM);
            z_q     <= alu_z;
            nvwe_q  <= (dec_q.kind == K_TEST_MEM);
            n_q     <= alu_n;
            v_q     <= alu_v;
            taken_q <= taken_nxt;
            cyc_q   <= dec_q.base_cyc + CYC_W'(taken_nxt);
        end
    end

    // outputs decoded from state
    always_comb begin
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        done   = 1'b0;
        busy   = 1'b1;
        unique case (state)
            S_IDLE:   busy   = 1'b0;
            S_READ:   mem_rd = 1'b1;
            S_EVAL:   ;
            S_WRITE:  mem_wr = 1'b1;
            S_FINISH: done   = 1'b1;
            default:  busy   = 1'b0;
        endcase
    end

    assign mem_addr   = dec_q.absolute ? ADDR_W'({hi_q, lo_q}) : ADDR_W'(lo_q);
    assign mem_wdata  = wdata_q;
    assign flag_z_we  = zwe_q;
    assign flag_z     = z_q;
    assign flag_nv_we = nvwe_q;
    assign flag_n     = n_q;
    assign flag_v     = v_q;
    assign br_taken   = taken_q;
    assign br_offset  = hi_q;
    assign br_target  = npc_q + {{EXT_W{hi_q[BYTE_W-1]}}, hi_q};
    assign cycles     = cyc_q;
endmodule

// File: rtl/membit_unit_chk.sv
module membit_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              flag_z_we,
    input logic              flag_nv_we,
    input logic              br_taken,
    input logic [2:0]        cycles,
    input logic              busy,
    input logic              done
);
    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    // R2
    taken_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (cycles == 3'd3));

    // R7
    nv_with_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_nv_we |-> flag_z_we);
endmodule

bind membit_unit membit_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/membit_unit_test.sv
`timescale 1ns/1ps
module membit_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, oper_lo = '0, oper_hi = '0, acc = '0;
    logic [15:0] next_pc = '0;
    logic [15:0] mem_addr, br_target;
    logic        mem_rd, mem_wr, flag_z_we, flag_z, flag_nv_we, flag_n, flag_v;
    logic        br_taken, busy, done;
    logic [7:0]  mem_wdata, br_offset;
    logic [7:0]  mem_rdata = '0;
    logic [2:0]  cycles;

    logic [7:0]  mem [0:511];
    int checks = 0, fails = 0;
    int rd_at, wr_at, done_at;

    always #2 clk = ~clk;

    membit_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .oper_lo(oper_lo), .oper_hi(oper_hi), .acc(acc), .next_pc(next_pc),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .flag_z_we(flag_z_we), .flag_z(flag_z), .flag_nv_we(flag_nv_we),
        .flag_n(flag_n), .flag_v(flag_v), .br_taken(br_taken),
        .br_offset(br_offset), .br_target(br_target), .cycles(cycles),
        .busy(busy), .done(done)
    );

    // behavioural memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
        if (mem_wr) mem[mem_addr[8:0]] <= mem_wdata;
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] a, input logic [15:0] npc);
        @(negedge clk);
        opcode = op; oper_lo = lo; oper_hi = hi; acc = a; next_pc = npc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rd_at = 0; wr_at = 0; done_at = 0;
        for (int i = 1; i <= 12; i++) begin
            if (mem_rd && rd_at == 0) rd_at = i;
            if (mem_wr) wr_at = i;
            if (done) begin
                done_at = i;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R8", "busy after reset", int'(busy), 0);
        chk("R8", "done after reset", int'(done), 0);
        chk("R8", "strobes after reset", int'({mem_rd, mem_wr}), 0);
    endtask

    task automatic t_bitmod;
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 2; p++) begin
                logic [7:0] init, exp;
                init = (p == 1) ? 8'h5A : 8'hA5;
                exp  = (p == 1) ? (init | (8'h01 << b)) : (init & ~(8'h01 << b));
                mem[9'h020 + 9'(b)] = init;
                run_op({p[0], b[2:0], 4'h7}, 8'h20 + 8'(b), 8'h00, 8'h00, 16'h0000);
                chk("R1", "bit modify result", int'(mem[9'h020 + 9'(b)]), int'(exp));
                chk("R1", "bit modify cycles", int'(cycles), 5);
            end
        end
        chk("R8", "read cycle", rd_at, 1);
        chk("R8", "write cycle", wr_at, 3);
        chk("R8", "done cycle with write", done_at, 4);
    endtask

    task automatic t_branch;
        mem[9'h040] = 8'h96;
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 2; p++) begin
                logic t;
                t = (((8'h96 >> b) & 8'h01) == 8'(p));
                run_op({p[0], b[2:0], 4'hF}, 8'h40, 8'h10, 8'h00, 16'h1000);
                chk("R2", "branch taken", int'(br_taken), int'(t));
                chk("R2", "branch cycles", int'(cycles), t ? 3 : 2);
                chk("R2", "branch no write", wr_at, 0);
                if (t) chk("R3", "branch target", int'(br_target), 16'h1010);
            end
        end
        chk("R8", "done cycle without write", done_at, 3);
        chk("R2", "offset output", int'(br_offset), 8'h10);
    endtask

    task automatic t_target;
        mem[9'h041] = 8'h01;
        run_op(8'h8F, 8'h41, 8'h20, 8'h00, 16'hFFF0);
        chk("R3", "target wraps upward", int'(br_target), 16'h0010);
        run_op(8'h8F, 8'h41, 8'h80, 8'h00, 16'h0005);
        chk("R3", "negative offset wraps", int'(br_target), 16'hFF85);
    endtask

    task automatic t_test_modify;
        mem[9'h010] = 8'h0F;
        mem[9'h110] = 8'h3C;
        run_op(8'h04, 8'h10, 8'h01, 8'hF0, 16'h0);
        chk("R4", "tset zp z", int'({flag_z_we, flag_z}), 3);
        chk("R4", "tset zp write", int'(mem[9'h010]), 8'hFF);
        chk("R5", "tset zp cycles", int'(cycles), 3);
        chk("R5", "abs byte untouched by zp", int'(mem[9'h110]), 8'h3C);
        run_op(8'h1C, 8'h10, 8'h01, 8'h0C, 16'h0);
        chk("R4", "tclr abs z", int'({flag_z_we, flag_z}), 2);
        chk("R4", "tclr abs write", int'(mem[9'h110]), 8'h30);
        chk("R5", "tclr abs cycles", int'(cycles), 4);
        mem[9'h011] = 8'hFF;
        run_op(8'h14, 8'h11, 8'h01, 8'h81, 16'h0);
        chk("R4", "tclr zp write", int'(mem[9'h011]), 8'h7E);
        chk("R5", "tclr zp cycles", int'(cycles), 3);
        mem[9'h112] = 8'h00;
        run_op(8'h0C, 8'h12, 8'h01, 8'h42, 16'h0);
        chk("R4", "tset abs z", int'(flag_z), 1);
        chk("R4", "tset abs write", int'(mem[9'h112]), 8'h42);
        chk("R5", "tset abs cycles", int'(cycles), 4);
    endtask

    task automatic t_test_imm;
        run_op(8'h89, 8'hC0, 8'h00, 8'h3F, 16'h0);
        chk("R6", "imm z set", int'({flag_z_we, flag_z}), 3);
        chk("R6", "imm leaves n/v", int'(flag_nv_we), 0);
        chk("R6", "imm no access", rd_at + wr_at, 0);
        chk("R6", "imm cycles", int'(cycles), 2);
        chk("R6", "imm done cycle", done_at, 2);
        run_op(8'h89, 8'h01, 8'h00, 8'h01, 16'h0);
        chk("R6", "imm z clear", int'(flag_z), 0);
    endtask

    task automatic t_test_mem;
        mem[9'h070] = 8'h80;
        mem[9'h170] = 8'h40;
        run_op(8'h24, 8'h70, 8'h01, 8'h80, 16'h0);
        chk("R7", "zp z/n/v", int'({flag_nv_we, flag_z, flag_n, flag_v}), 4'b1010);
        chk("R7", "zp cycles", int'(cycles), 3);
        chk("R7", "zp no write", wr_at, 0);
        run_op(8'h2C, 8'h70, 8'h01, 8'h01, 16'h0);
        chk("R7", "abs z/n/v", int'({flag_nv_we, flag_z, flag_n, flag_v}), 4'b1101);
        chk("R7", "abs cycles", int'(cycles), 4);
    endtask

    task automatic t_busy_ignore;
        int extra;
        mem[9'h050] = 8'h00;
        mem[9'h060] = 8'h00;
        @(negedge clk);
        opcode = 8'h87; oper_lo = 8'h50; oper_hi = 8'h00; acc = 8'h00; start = 1'b1;
        @(negedge clk);
        opcode = 8'h97; oper_lo = 8'h60;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8 && !done; i++) @(negedge clk);
        extra = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (busy || done || mem_rd) extra++;
        end
        chk("R9", "first op applied", int'(mem[9'h050]), 8'h01);
        chk("R9", "ignored op not applied", int'(mem[9'h060]), 8'h00);
        chk("R9", "no second instruction", extra, 0);
    endtask

    task automatic t_unsupported;
        run_op(8'hEA, 8'h50, 8'h00, 8'hFF, 16'h0);
        chk("R10", "done next cycle", done_at, 1);
        chk("R10", "no access", rd_at + wr_at, 0);
        chk("R10", "no flag or branch", int'({flag_z_we, flag_nv_we, br_taken}), 0);
        chk("R10", "zero cycles", int'(cycles), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog: got no finish expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_bitmod();
        t_branch();
        t_target();
        t_test_modify();
        t_test_imm();
        t_test_mem();
        t_busy_ignore();
        t_unsupported();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule